// File: doc/BRIEF.md
# DMA Request Router for Multi-Channel Audio FIFOs

This block sits between twenty channel FIFOs and a five-line DMA engine. Ten capture FIFOs report an almost-full condition, and ten playback FIFOs report an almost-empty condition. Each of the five request lines has two source fields, one for capture and one for playback. A line is driven high when either chosen channel has DMA enabled and is at its watermark.

In the other direction, each channel holds a field that names the acknowledge line it answers to. An acknowledge pulse on a line produces a one-cycle strobe for every enabled channel bound to that line. Capture channels receive a pop strobe and playback channels receive a push strobe. The FIFOs then move one word on that strobe.

Configuration is loaded through a simple write-only word port. All outputs are registered.

Top module: `dma_req_router`

## Requirements
- R1: After reset all request lines and all strobes are low. Every source field and every acknowledge field resets to 15 (unused), and every enable bit resets to 0. As a result, no request rises after reset even when all watermark inputs are high and every channel is enabled.
- R2: A write to address 0 loads the enable word. Capture channel n is bit n, and playback channel n is bit 16+n.
- R3: Address 1 holds the capture source fields, where line k uses bits 4k+3..4k. One cycle after its inputs, line k is high if the named capture channel is enabled and its almost-full input is high.
- R4: Address 2 holds the playback source fields in the same layout. Line k is high one cycle after the named playback channel is enabled with its almost-empty input high.
- R5: A channel whose enable bit is 0 never drives a request line, whatever its watermark input.
- R6: A source field value of 10 to 15 contributes nothing to its line.
- R7: The capture and playback contributions to a line are ORed.
- R8: The capture acknowledge fields live at two addresses. Address 3 holds channels 0..7, with channel n at bits 4n+3..4n. Address 4 holds channels 8 and 9 at bits 3..0 and 7..4. One cycle after an acknowledge on line k, every enabled capture channel whose field equals k sees a single-cycle pop strobe.
- R9: The playback acknowledge fields use the same layout at addresses 5 (channels 0..7) and 6 (channels 8..9), and produce push strobes.
- R10: A disabled channel gets no strobe. An acknowledge field of 5 to 15 never matches any line.
- R11: Writes to address 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Configuration word address |
| wr_data | input | 32 | Configuration write data |
| cap_af | input | 10 | Capture FIFO almost-full flags |
| pb_ae | input | 10 | Playback FIFO almost-empty flags |
| dma_ack | input | 5 | Acknowledge pulses from the DMA engine |
| dma_req | output | 5 | Registered DMA request lines |
| cap_pop | output | 10 | Registered capture pop strobes |
| pb_push | output | 10 | Registered playback push strobes |

## Verification
The hardest case to reach is one line bound to several channels at once: two capture channels and one playback channel share an acknowledge line. That same setup also binds channels 8 and 9 through the second acknowledge word. The stimulus programs all four acknowledge words so that one pulse fans out to three strobes, and so that each upper channel lands on a different line. It then disables one of the sharing channels and pulses again, which shows that the remaining bindings still fire. On the request side, the vector table drives watermark patterns that combine an out-of-range source field and a disabled channel with valid sources on other lines.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_EN         = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CAP_SRC    = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_PB_SRC     = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CAP_ACK_LO = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CAP_ACK_HI = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_PB_ACK_LO  = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_PB_ACK_HI  = 3'd6;
endpackage

// File: rtl/router_regs.sv
module router_regs
  import router_pkg::*;
#(
  parameter int NCH   = 10,
  parameter int NLINE = 5,
  parameter int SELW  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [NCH-1:0]          cap_en,
  output logic [NCH-1:0]          pb_en,
  output logic [NLINE*SELW-1:0]   cap_src,
  output logic [NLINE*SELW-1:0]   pb_src,
  output logic [NCH*SELW-1:0]     cap_ack,
  output logic [NCH*SELW-1:0]     pb_ack
);
  localparam int PB_EN_OFS = DATA_W / 2;
  localparam int NIB       = DATA_W / SELW;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_en  <= '0;
      pb_en   <= '0;
      cap_src <= '1;
      pb_src  <= '1;
    end else if (wr_en) begin
      if (wr_addr == ADDR_EN) begin
        cap_en <= wr_data[NCH-1:0];
        pb_en  <= wr_data[PB_EN_OFS +: NCH];
      end
      if (wr_addr == ADDR_CAP_SRC) cap_src <= wr_data[NLINE*SELW-1:0];
      if (wr_addr == ADDR_PB_SRC)  pb_src  <= wr_data[NLINE*SELW-1:0];
    end
  end

  // Per-channel acknowledge fields; channels past one word spill to the next.
  for (genvar c = 0; c < NCH; c++) begin : g_ack
    localparam int POS = c % NIB;
    localparam logic [ADDR_W-1:0] CAP_A = (c < NIB) ? ADDR_CAP_ACK_LO : ADDR_CAP_ACK_HI;
    localparam logic [ADDR_W-1:0] PB_A  = (c < NIB) ? ADDR_PB_ACK_LO  : ADDR_PB_ACK_HI;
    always_ff @(posedge clk) begin
      if (rst) begin
        cap_ack[c*SELW +: SELW] <= '1;
        pb_ack[c*SELW +: SELW]  <= '1;
      end else if (wr_en) begin
        if (wr_addr == CAP_A) cap_ack[c*SELW +: SELW] <= wr_data[POS*SELW +: SELW];
        if (wr_addr == PB_A)  pb_ack[c*SELW +: SELW]  <= wr_data[POS*SELW +: SELW];
      end
    end
  end

  // R11: source fields only move on a write to their own address
  a_r11_src_hold: assert property (@(posedge clk) disable iff (rst)
    !($past(wr_en) && $past(wr_addr) == ADDR_CAP_SRC) |-> $stable(cap_src));
  a_r11_en_hold: assert property (@(posedge clk) disable iff (rst)
    !($past(wr_en) && $past(wr_addr) == ADDR_EN) |-> $stable(cap_en) && $stable(pb_en));
endmodule

// File: rtl/req_mux.sv
module req_mux #(
  parameter int NCH   = 10,
  parameter int NLINE = 5,
  parameter int SELW  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        cap_en,
  input  logic [NCH-1:0]        pb_en,
  input  logic [NLINE*SELW-1:0] cap_src,
  input  logic [NLINE*SELW-1:0] pb_src,
  input  logic [NCH-1:0]        cap_af,
  input  logic [NCH-1:0]        pb_ae,
  output logic [NLINE-1:0]      dma_req
);
  localparam int SPAN = 1 << SELW;

  // Zero-extended so that out-of-range selects read a 0.
  logic [SPAN-1:0] cap_ok, pb_ok;
  assign cap_ok = SPAN'(cap_en & cap_af);
  assign pb_ok  = SPAN'(pb_en & pb_ae);

  for (genvar k = 0; k < NLINE; k++) begin : g_line
    logic [SELW-1:0] cs, ps;
    assign cs = cap_src[k*SELW +: SELW];
    assign ps = pb_src[k*SELW +: SELW];
    always_ff @(posedge clk) begin
      if (rst) dma_req[k] <= 1'b0;
      else     dma_req[k] <= cap_ok[cs] | pb_ok[ps];
    end

    // R6: with both fields out of range the line stays low
    a_r6_invalid_quiet: assert property (@(posedge clk) disable iff (rst)
      ($past(cs) >= NCH && $past(ps) >= NCH) |-> !dma_req[k]);
    // R5: a request implies some channel was enabled
    a_r5_req_needs_en: assert property (@(posedge clk) disable iff (rst)
      dma_req[k] |-> $past(|{cap_en, pb_en}));
  end
endmodule

// File: rtl/ack_decode.sv
module ack_decode #(
  parameter int NCH   = 10,
  parameter int NLINE = 5,
  parameter int SELW  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NCH-1:0]      en,
  input  logic [NCH*SELW-1:0] ack_sel,
  input  logic [NLINE-1:0]    dma_ack,
  output logic [NCH-1:0]      strobe
);
  localparam int SPAN = 1 << SELW;

  logic [SPAN-1:0] ack_ext;
  assign ack_ext = SPAN'(dma_ack);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SELW-1:0] sel;
    assign sel = ack_sel[c*SELW +: SELW];
    always_ff @(posedge clk) begin
      if (rst) strobe[c] <= 1'b0;
      else     strobe[c] <= en[c] & ack_ext[sel];
    end

    // R10: no strobe for a channel that was disabled
    a_r10_strobe_needs_en: assert property (@(posedge clk) disable iff (rst)
      strobe[c] |-> $past(en[c]));
    // R8: a strobe follows an acknowledge one cycle earlier
    a_r8_strobe_needs_ack: assert property (@(posedge clk) disable iff (rst)
      strobe[c] |-> $past(|dma_ack));
  end
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import router_pkg::*;
#(
  parameter int NCH   = 10,
  parameter int NLINE = 5,
  parameter int SELW  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NCH-1:0]    cap_af,
  input  logic [NCH-1:0]    pb_ae,
  input  logic [NLINE-1:0]  dma_ack,
  output logic [NLINE-1:0]  dma_req,
  output logic [NCH-1:0]    cap_pop,
  output logic [NCH-1:0]    pb_push
);
  logic [NCH-1:0]        cap_en, pb_en;
  logic [NLINE*SELW-1:0] cap_src, pb_src;
  logic [NCH*SELW-1:0]   cap_ack, pb_ack;

  router_regs #(.NCH(NCH), .NLINE(NLINE), .SELW(SELW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_en(cap_en), .pb_en(pb_en), .cap_src(cap_src), .pb_src(pb_src),
    .cap_ack(cap_ack), .pb_ack(pb_ack));

  req_mux #(.NCH(NCH), .NLINE(NLINE), .SELW(SELW)) u_req (
    .clk(clk), .rst(rst), .cap_en(cap_en), .pb_en(pb_en),
    .cap_src(cap_src), .pb_src(pb_src), .cap_af(cap_af), .pb_ae(pb_ae),
    .dma_req(dma_req));

  ack_decode #(.NCH(NCH), .NLINE(NLINE), .SELW(SELW)) u_cap_ack (
    .clk(clk), .rst(rst), .en(cap_en), .ack_sel(cap_ack),
    .dma_ack(dma_ack), .strobe(cap_pop));

  ack_decode #(.NCH(NCH), .NLINE(NLINE), .SELW(SELW)) u_pb_ack (
    .clk(clk), .rst(rst), .en(pb_en), .ack_sel(pb_ack),
    .dma_ack(dma_ack), .strobe(pb_push));

  // R8: strobes are single-cycle for a single-cycle acknowledge
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ($past(dma_ack) == '0) |-> (cap_pop == '0 && pb_push == '0));
endmodule

// File: tb/sim_dma_req_router.sv
module sim_dma_req_router;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [9:0]  cap_af, pb_ae, cap_pop, pb_push;
  logic [4:0]  dma_ack, dma_req;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dma_req_router u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_af(cap_af), .pb_ae(pb_ae), .dma_ack(dma_ack),
    .dma_req(dma_req), .cap_pop(cap_pop), .pb_push(pb_push));

  // {cap_af, pb_ae, expected dma_req}
  // Setup: line0=cap3, line1=cap9, line2=pb5 (cap field 12 unused),
  //        line3=cap0 (disabled), line4=pb8.
  localparam logic [24:0] VEC [10] = '{
    {10'h000, 10'h000, 5'h00},
    {10'h008, 10'h000, 5'h01},
    {10'h200, 10'h000, 5'h02},
    {10'h001, 10'h000, 5'h00},
    {10'h3FF, 10'h000, 5'h03},
    {10'h000, 10'h020, 5'h04},
    {10'h000, 10'h100, 5'h10},
    {10'h000, 10'h3FF, 5'h14},
    {10'h3FF, 10'h3FF, 5'h17},
    {10'h3F7, 10'h1DF, 5'h12}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_ack(input logic [4:0] a, input logic [9:0] ecap,
                           input logic [9:0] epb, input string tag);
    @(negedge clk);
    dma_ack = a;
    @(negedge clk);
    dma_ack = '0;
    chk({tag, " pop"}, 32'(cap_pop), 32'(ecap));
    chk({tag, " push"}, 32'(pb_push), 32'(epb));
    @(negedge clk);
    chk({tag, " pop clears"}, 32'(cap_pop), 32'h0);
    chk({tag, " push clears"}, 32'(pb_push), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    cap_af = '1; pb_ae = '1; dma_ack = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 req after reset", 32'(dma_req), 32'h0);
    chk("R1 pop after reset", 32'(cap_pop), 32'h0);
    // R1/R2: enable all, selects still at reset value -> no request
    wr(3'd0, 32'h03FF_03FF);
    @(negedge clk);
    chk("R1 sources unused after reset", 32'(dma_req), 32'h0);
    pulse_ack(5'h1F, 10'h000, 10'h000, "R1 ack fields unused after reset");

    // R2 R3 R4 R5 R6 R7: capture ch0 disabled
    wr(3'd0, 32'h03FF_03FE);
    wr(3'd1, 32'h000F_0C93);
    wr(3'd2, 32'h0008_F5FF);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      cap_af = VEC[i][24:15];
      pb_ae  = VEC[i][14:5];
      @(negedge clk);
      chk($sformatf("R3 R4 R5 R6 R7 vector %0d", i), 32'(dma_req), 32'(VEC[i][4:0]));
    end

    // R11: address 7 write has no effect
    cap_af = 10'h008; pb_ae = '0;
    wr(3'd7, 32'h0000_0000);
    @(negedge clk);
    chk("R11 unused address ignored", 32'(dma_req), 32'h01);
    // R2: playback bit position
    pb_ae = 10'h020;
    wr(3'd0, 32'h03DF_03FE);
    @(negedge clk);
    chk("R2 playback enable bit 16+n", 32'(dma_req), 32'h01);
    wr(3'd0, 32'h03FF_03FE);
    cap_af = '0; pb_ae = '0;

    // R8 R9: acknowledge routing
    wr(3'd3, 32'hFFF2_FF2F);   // cap ch1, ch4 -> line 2
    wr(3'd4, 32'hFFFF_FF40);   // cap ch8 -> line 0, ch9 -> line 4
    wr(3'd5, 32'hFFFF_FFF2);   // pb ch0 -> line 2
    wr(3'd6, 32'hFFFF_FF1F);   // pb ch9 -> line 1
    pulse_ack(5'h04, 10'h012, 10'h001, "R8 R9 shared line 2");
    pulse_ack(5'h01, 10'h100, 10'h000, "R8 ch8 upper word");
    pulse_ack(5'h10, 10'h200, 10'h000, "R8 ch9 upper word");
    pulse_ack(5'h02, 10'h000, 10'h200, "R9 pb ch9 upper word");
    pulse_ack(5'h08, 10'h000, 10'h000, "R10 line with no binding");
    pulse_ack(5'h1F, 10'h312, 10'h201, "R8 R9 all lines");
    // R10: disable capture ch1
    wr(3'd0, 32'h03FF_03FC);
    pulse_ack(5'h04, 10'h010, 10'h001, "R10 disabled channel");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule